// File: doc/BRIEF.md
# Standby Mode Clock Controller

This block decides which clocks and oscillators run in a small microcontroller. It has five states: reset, run, halt, stop, and a wake phase that follows stop. The CPU raises one-cycle halt or stop requests. A pending interrupt brings the core back to run. From its state the controller drives enables for the CPU clock, the system oscillator, the peripheral clock, the low-speed internal oscillator and the watchdog clock.

The low-speed oscillator has two controls:
- A configuration bit, captured once as reset ends. It says whether software may stop the oscillator at all.
- A software stop bit, written from run mode. It takes effect only when the configuration allows it.

A watchdog clocked from the low-speed oscillator loses its clock whenever that oscillator is stopped. On leaving stop, the system oscillator is enabled first. The CPU and peripheral clocks follow after a programmable settling count.

Top module: `stby_clk_ctrl`

## Requirements
- R1: While `rst_n` is low, all five enable outputs are 0.
- R2: At the first rising clock edge with `rst_n` high, the block enters run. In run, `cpu_clk_en`, `sysosc_en` and `periph_clk_en` are 1, and the software stop bit is cleared to 0.
- R3: In halt, `cpu_clk_en` is 0, while `sysosc_en` and `periph_clk_en` stay 1.
- R4: In stop, `cpu_clk_en`, `sysosc_en` and `periph_clk_en` are all 0.
- R5: In halt and stop, `lsosc_en` keeps the value it had in run just before entry.
- R6: When the captured configuration `ls_nostop_cfg` is 1, `lsosc_en` is 1 in every state except reset, and the software stop bit has no effect.
- R7: When the captured configuration is 0, `lsosc_en` equals the inverse of the software stop bit outside reset. A write (`ls_mode_we`=1) loads `ls_mode_wdata` into that bit only in run. Writes in halt are ignored.
- R8: `ls_nostop_cfg` is sampled only at the first clock edge after reset. Later changes have no effect until the next reset.
- R9: `wdt_clk_en` equals `lsosc_en` when `wdt_on_ls` is 1, and equals `sysosc_en` when it is 0.
- R10: `irq_pend` in halt returns the block to run at the next clock edge, with no wake phase.
- R11: `irq_pend` in stop enters a wake phase at the next edge. The wake phase has `sysosc_en`=1 and `cpu_clk_en`=`periph_clk_en`=0, and lasts exactly `settle_cycles`+1 cycles before run.
- R12: `halt_req` and `stop_req` act only in run. If both are high in the same cycle, the block enters stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | One-cycle request to enter halt |
| stop_req | input | 1 | One-cycle request to enter stop |
| irq_pend | input | 1 | Interrupt pending, releases standby |
| ls_nostop_cfg | input | 1 | Power-up setting: 1 means the low-speed oscillator cannot be stopped |
| ls_mode_we | input | 1 | Write strobe for the software stop bit |
| ls_mode_wdata | input | 1 | Value written to the software stop bit (1 = stop) |
| wdt_on_ls | input | 1 | Watchdog is clocked from the low-speed oscillator |
| settle_cycles | input | CNT_W | Wake settling count |
| cpu_clk_en | output | 1 | CPU clock enable |
| sysosc_en | output | 1 | System oscillator enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| lsosc_en | output | 1 | Low-speed oscillator enable |
| wdt_clk_en | output | 1 | Watchdog clock enable |

## Verification
The bench sweeps every combination of the configuration bit, the stop bit, the watchdog source and the standby path, and checks all five enables against a model of the state.

It targets these corner cases:
- A write to the stop bit while in halt. A design that accepts it would come back from halt with the low-speed oscillator in the wrong state.
- A change of the configuration input after reset. A design that keeps sampling it would let software stop a locked oscillator.
- Halt and stop requested in the same cycle. If the priority is inverted, the system oscillator keeps running.
- A stop request arriving in halt. If it is not ignored, the block drops into stop.
- The wake phase, timed for several settling counts, including zero. An off-by-one in the counter shortens or lengthens it by one cycle.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [2:0] {
    ST_RST  = 3'd0,
    ST_RUN  = 3'd1,
    ST_HALT = 3'd2,
    ST_STOP = 3'd3,
    ST_WAKE = 3'd4
  } stby_state_e;

  // Low-speed oscillator runs unless software stop is both requested and permitted.
  function automatic logic ls_running(input logic nostop_cfg, input logic sw_stop);
    return nostop_cfg | ~sw_stop;
  endfunction

  // Stop wins over halt when both arrive together.
  function automatic stby_state_e run_next(input logic halt_r, input logic stop_r);
    if (stop_r)      return ST_STOP;
    else if (halt_r) return ST_HALT;
    else             return ST_RUN;
  endfunction
endpackage

// File: rtl/stby_fsm.sv
module stby_fsm
  import stby_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_req,
  input  logic             stop_req,
  input  logic             irq_pend,
  input  logic [CNT_W-1:0] settle_cycles,
  output stby_state_e      st_q,
  output logic [CNT_W-1:0] wake_cnt_q,
  output logic             ev_wake_done
);
  stby_state_e st_d;

  function automatic logic settle_hit(input logic [CNT_W-1:0] cnt, input logic [CNT_W-1:0] lim);
    return cnt == lim;
  endfunction

  assign ev_wake_done = (st_q == ST_WAKE) && settle_hit(wake_cnt_q, settle_cycles);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RST:  st_d = ST_RUN;
      ST_RUN:  st_d = run_next(halt_req, stop_req);
      ST_HALT: if (irq_pend) st_d = ST_RUN;
      ST_STOP: if (irq_pend) st_d = ST_WAKE;
      ST_WAKE: if (ev_wake_done) st_d = ST_RUN;
      default: st_d = ST_RST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_RST;
      wake_cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q != ST_WAKE)    wake_cnt_q <= '0;
      else if (!ev_wake_done) wake_cnt_q <= wake_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/stby_ls_ctrl.sv
module stby_ls_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_load,
  input  logic cfg_in,
  input  logic wr_ok,
  input  logic wr_en,
  input  logic wr_data,
  output logic cfg_lock_q,
  output logic sw_stop_q,
  output logic ls_run
);
  // The configuration resets to "cannot stop", the safe default until it is captured.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_lock_q <= 1'b1;
      sw_stop_q  <= 1'b0;
    end else begin
      if (cfg_load)      cfg_lock_q <= cfg_in;
      if (wr_ok && wr_en) sw_stop_q <= wr_data;
    end
  end

  assign ls_run = stby_pkg::ls_running(cfg_lock_q, sw_stop_q);
endmodule

// File: rtl/stby_gate_dec.sv
module stby_gate_dec
  import stby_pkg::*;
(
  input  stby_state_e st,
  input  logic        ls_run,
  input  logic        wdt_on_ls,
  output logic        cpu_en,
  output logic        sys_en,
  output logic        per_en,
  output logic        ls_en,
  output logic        wdt_en
);
  always_comb begin
    cpu_en = (st == ST_RUN);
    sys_en = (st == ST_RUN) || (st == ST_HALT) || (st == ST_WAKE);
    per_en = (st == ST_RUN) || (st == ST_HALT);
    ls_en  = (st != ST_RST) && ls_run;
    wdt_en = wdt_on_ls ? ls_en : sys_en;
  end
endmodule

// File: rtl/stby_clk_ctrl.sv
module stby_clk_ctrl
  import stby_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_req,
  input  logic             stop_req,
  input  logic             irq_pend,
  input  logic             ls_nostop_cfg,
  input  logic             ls_mode_we,
  input  logic             ls_mode_wdata,
  input  logic             wdt_on_ls,
  input  logic [CNT_W-1:0] settle_cycles,
  output logic             cpu_clk_en,
  output logic             sysosc_en,
  output logic             periph_clk_en,
  output logic             lsosc_en,
  output logic             wdt_clk_en
);
  stby_state_e      st_q;
  logic [CNT_W-1:0] wake_cnt_q;
  logic             ev_wake_done;
  logic             ev_cfg_load;
  logic             ev_run;
  logic             cfg_lock_q;
  logic             sw_stop_q;
  logic             ls_run;

  assign ev_cfg_load = (st_q == ST_RST);
  assign ev_run      = (st_q == ST_RUN);

  stby_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .stop_req(stop_req),
    .irq_pend(irq_pend), .settle_cycles(settle_cycles),
    .st_q(st_q), .wake_cnt_q(wake_cnt_q), .ev_wake_done(ev_wake_done)
  );

  stby_ls_ctrl u_ls (
    .clk(clk), .rst_n(rst_n), .cfg_load(ev_cfg_load), .cfg_in(ls_nostop_cfg),
    .wr_ok(ev_run), .wr_en(ls_mode_we), .wr_data(ls_mode_wdata),
    .cfg_lock_q(cfg_lock_q), .sw_stop_q(sw_stop_q), .ls_run(ls_run)
  );

  stby_gate_dec u_dec (
    .st(st_q), .ls_run(ls_run), .wdt_on_ls(wdt_on_ls),
    .cpu_en(cpu_clk_en), .sys_en(sysosc_en), .per_en(periph_clk_en),
    .ls_en(lsosc_en), .wdt_en(wdt_clk_en)
  );
endmodule

// File: rtl/stby_clk_ctrl_chk.sv
module stby_clk_ctrl_chk
  import stby_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             halt_req,
  input logic             stop_req,
  input logic             irq_pend,
  input logic             wdt_on_ls,
  input stby_state_e      st_q,
  input logic             cfg_lock_q,
  input logic             ev_wake_done,
  input logic             cpu_clk_en,
  input logic             sysosc_en,
  input logic             periph_clk_en,
  input logic             lsosc_en,
  input logic             wdt_clk_en
);
  a_r1_reset_off: assert property (@(posedge clk)
    !rst_n |-> !cpu_clk_en && !sysosc_en && !periph_clk_en && !lsosc_en && !wdt_clk_en);

  a_r3_halt_gates_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_HALT |-> !cpu_clk_en && sysosc_en && periph_clk_en);

  a_r4_stop_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_STOP |-> !cpu_clk_en && !sysosc_en && !periph_clk_en);

  a_r5_ls_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HALT || st_q == ST_STOP) && $past(st_q) != ST_RST |-> lsosc_en == $past(lsosc_en));

  a_r6_locked_runs: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_lock_q && st_q != ST_RST |-> lsosc_en);

  a_r9_wdt_held: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_on_ls && !lsosc_en |-> !wdt_clk_en);

  a_r10_halt_release: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_HALT && irq_pend |=> st_q == ST_RUN);

  a_r11_wake_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wake_done |=> cpu_clk_en && periph_clk_en);

  a_r12_stop_priority: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_RUN && halt_req && stop_req |=> st_q == ST_STOP);
endmodule

bind stby_clk_ctrl stby_clk_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .stop_req(stop_req),
  .irq_pend(irq_pend), .wdt_on_ls(wdt_on_ls), .st_q(st_q), .cfg_lock_q(cfg_lock_q),
  .ev_wake_done(ev_wake_done), .cpu_clk_en(cpu_clk_en), .sysosc_en(sysosc_en),
  .periph_clk_en(periph_clk_en), .lsosc_en(lsosc_en), .wdt_clk_en(wdt_clk_en)
);

// File: tb/tb_stby_clk_ctrl.sv
module tb_stby_clk_ctrl;
  localparam int CNT_W = 8;
  localparam int M_RST = 0, M_RUN = 1, M_HALT = 2, M_STOP = 3, M_WAKE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 0, stop_req = 0, irq_pend = 0;
  logic ls_nostop_cfg = 0, ls_mode_we = 0, ls_mode_wdata = 0, wdt_on_ls = 0;
  logic [CNT_W-1:0] settle_cycles = '0;
  logic cpu_clk_en, sysosc_en, periph_clk_en, lsosc_en, wdt_clk_en;
  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  stby_clk_ctrl #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .stop_req(stop_req),
    .irq_pend(irq_pend), .ls_nostop_cfg(ls_nostop_cfg), .ls_mode_we(ls_mode_we),
    .ls_mode_wdata(ls_mode_wdata), .wdt_on_ls(wdt_on_ls), .settle_cycles(settle_cycles),
    .cpu_clk_en(cpu_clk_en), .sysosc_en(sysosc_en), .periph_clk_en(periph_clk_en),
    .lsosc_en(lsosc_en), .wdt_clk_en(wdt_clk_en)
  );

  // Expected {cpu, sys, periph, ls, wdt}, rebuilt from the requirements.
  function automatic logic [4:0] expv(int mode, bit cfg, bit sw, bit ws);
    logic c, s, p, l;
    c = (mode == M_RUN);
    s = (mode == M_RUN) || (mode == M_HALT) || (mode == M_WAKE);
    p = (mode == M_RUN) || (mode == M_HALT);
    l = (mode != M_RST) && (cfg || !sw);
    return {c, s, p, l, ws ? l : s};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [4:0] exp);
    logic [4:0] got;
    got = {cpu_clk_en, sysosc_en, periph_clk_en, lsosc_en, wdt_clk_en};
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: enables {cpu,sys,per,ls,wdt} got %b expected %b", req, got, exp);
    end
  endtask

  task automatic do_reset(bit cfg);
    rst_n = 0; halt_req = 0; stop_req = 0; irq_pend = 0; ls_mode_we = 0;
    ls_nostop_cfg = cfg;
    tick();
    tick();
    check("R1 reset", 5'b00000);
    rst_n = 1;
    tick();
    check("R2 run after reset", 5'b11111);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int cfg = 0; cfg < 2; cfg++)
      for (int sw = 0; sw < 2; sw++)
        for (int ws = 0; ws < 2; ws++)
          for (int path = 0; path < 2; path++) begin
            int st;
            st = (cfg * 4 + sw * 2 + ws + path) % 6;
            settle_cycles = CNT_W'(st);
            wdt_on_ls = ws[0];
            do_reset(cfg[0]);
            ls_nostop_cfg = !cfg[0];                      // R8: late change must not count
            ls_mode_we = 1; ls_mode_wdata = sw[0];
            tick();
            ls_mode_we = 0;
            check("R6 R7 R8 R9 run after write", expv(M_RUN, cfg[0], sw[0], ws[0]));
            if (path == 0) begin
              halt_req = 1;
              tick();
              halt_req = 0;
              check("R3 R5 halt", expv(M_HALT, cfg[0], sw[0], ws[0]));
              ls_mode_we = 1; ls_mode_wdata = !sw[0]; stop_req = 1;
              tick();
              ls_mode_we = 0; stop_req = 0;
              check("R12 stop ignored in halt", expv(M_HALT, cfg[0], sw[0], ws[0]));
              irq_pend = 1;
              tick();
              irq_pend = 0;
              check("R10 R7 halt release, write ignored", expv(M_RUN, cfg[0], sw[0], ws[0]));
            end else begin
              halt_req = 1; stop_req = 1;
              tick();
              halt_req = 0; stop_req = 0;
              check("R4 R5 R12 stop priority", expv(M_STOP, cfg[0], sw[0], ws[0]));
              tick();
              check("R4 stop held", expv(M_STOP, cfg[0], sw[0], ws[0]));
              irq_pend = 1;
              tick();
              irq_pend = 0;
              check("R11 wake entry", expv(M_WAKE, cfg[0], sw[0], ws[0]));
              for (int k = 0; k < st; k++) begin
                tick();
                check("R11 wake length", expv(M_WAKE, cfg[0], sw[0], ws[0]));
              end
              tick();
              check("R11 run after settle", expv(M_RUN, cfg[0], sw[0], ws[0]));
            end
          end
    // R7: with stopping permitted, the bit toggles the oscillator both ways.
    wdt_on_ls = 1;
    do_reset(1'b0);
    ls_mode_we = 1; ls_mode_wdata = 1;
    tick();
    check("R7 R9 stop bit set", expv(M_RUN, 1'b0, 1'b1, 1'b1));
    ls_mode_wdata = 0;
    tick();
    ls_mode_we = 0;
    check("R7 R9 stop bit cleared", expv(M_RUN, 1'b0, 1'b0, 1'b1));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule